// File: doc/BRIEF.md
# Dual-Output Multi-Mode PWM Generator

One PWM channel that drives a high-side and a low-side pin from a single free-running period counter. Software-style register writes land in a staging layer: two duty values (A and B), a period value and a mode. At each period boundary the staged values are copied into the active set, with duty values clamped to a legal pulse-width window on the way. Because the copy happens only at the boundary, a waveform is never cut short or stretched by a write in mid-period.

The mode decides how the two comparisons reach the pins. In independent mode duty A shapes the high side and duty B the low side. Complementary mode drives the low side as the inverse of the high side. Redundant mode copies the high-side waveform to both pins. Push-pull mode sends the duty-A pulse to one pin per period and alternates pins from period to period. Duty B matters only in independent mode. The write port is a plain control interface with no back-pressure: a write is accepted in any cycle where `wr_en` is high.

Top module: `pwm_dual_gen`

## Requirements
- R1: While `rst_n` is low and after its release, both outputs are low. All duty values reset to zero, the mode resets to independent, and the period resets to the `PER_RESET` parameter. The counter starts at zero.
- R2: The counter counts from 0 up to the active period value P and then returns to 0, so one period lasts P+1 cycles. An output that is driven from a comparison is high exactly while the counter is below the effective duty value.
- R3: A write selects its target with `wr_sel`: 0 is duty A, 1 is duty B, 2 is period, 3 is mode. A written value has no effect on the outputs until the first cycle after the next counter wrap.
- R4: When `wr_data[1:0]` written to the mode has the value 0 (independent), the high side follows duty A and the low side follows duty B.
- R5: Mode code 1 (complementary): the high side follows duty A and the low side is its inverse in every cycle.
- R6: Mode code 2 (redundant): both outputs carry the duty-A waveform.
- R7: Mode code 3 (push-pull): the first period after push-pull takes effect drives the duty-A pulse on the high side with the low side held low. Each later push-pull period swaps the roles of the two pins.
- R8: In any mode other than independent, duty B has no effect on either output.
- R9: A duty value of zero holds the output it controls low for the whole period.
- R10: A nonzero duty value below `DUTY_MIN` (8) takes effect as 8.
- R11: A duty value above `DUTY_MAX` (0xFFEF) takes effect as 0xFFEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_sel | input | 2 | Register select: 0 duty A, 1 duty B, 2 period, 3 mode |
| wr_data | input | W | Write data. The mode uses bits [1:0]. |
| pwm_hi | output | 1 | High-side PWM output |
| pwm_lo | output | 1 | Low-side PWM output |

## Verification
The bench builds the block with the full 16-bit width and the default clamp limits. It sets `PER_RESET` to 15, so the first period boundary arrives within a few cycles and the reset values can be seen to hand over to written ones. With the full width, a period of 0xFFF0 and a duty of 0xFFFF fit in one run of about 65k cycles, which makes the upper clamp visible as exactly two low cycles at the end of the period. Short random periods between 8 and 40 keep many boundaries, mode changes and push-pull swaps within reach.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MODE_INDEP    = 2'd0,
    MODE_COMPL    = 2'd1,
    MODE_REDUN    = 2'd2,
    MODE_PUSHPULL = 2'd3
  } pwm_mode_e;

  typedef enum logic [1:0] {
    SEL_DUTY_A = 2'd0,
    SEL_DUTY_B = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_MODE   = 2'd3
  } reg_sel_e;

  localparam int NUM_DUTY = 2;
endpackage

// File: rtl/pwm_duty_clamp.sv
module pwm_duty_clamp #(
  parameter int          W        = 16,
  parameter logic [W-1:0] DUTY_MIN = 8,
  parameter logic [W-1:0] DUTY_MAX = 16'hFFEF
) (
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  always_comb begin
    if (d_in == '0)            d_out = '0;
    else if (d_in < DUTY_MIN)  d_out = DUTY_MIN;
    else if (d_in > DUTY_MAX)  d_out = DUTY_MAX;
    else                       d_out = d_in;
  end

  // R10 / R11: any nonzero input lands inside the legal window
  always_comb begin
    if (d_in != '0) begin
      p_clamp_window_r10: assert (d_out >= DUTY_MIN && d_out <= DUTY_MAX)
        else $error("clamp output outside window");
    end
  end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_pkg::*;
#(
  parameter int           W         = 16,
  parameter logic [W-1:0] PER_RESET = '1,
  parameter logic [W-1:0] DUTY_MIN  = 8,
  parameter logic [W-1:0] DUTY_MAX  = 16'hFFEF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  reg_sel_e  wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic      load,
  output logic [W-1:0] act_duty_a,
  output logic [W-1:0] act_duty_b,
  output logic [W-1:0] act_per,
  output pwm_mode_e act_mode,
  output pwm_mode_e nxt_mode
);
  logic [W-1:0] st_duty [NUM_DUTY];
  logic [W-1:0] clamped [NUM_DUTY];
  logic [W-1:0] act_duty [NUM_DUTY];
  logic [W-1:0] st_per;
  pwm_mode_e    st_mode;

  for (genvar i = 0; i < NUM_DUTY; i++) begin : g_duty
    pwm_duty_clamp #(.W(W), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)) u_clamp (
      .d_in  (st_duty[i]),
      .d_out (clamped[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_duty[i]  <= '0;
        act_duty[i] <= '0;
      end else begin
        if (wr_en && wr_sel == reg_sel_e'(i)) st_duty[i] <= wr_data;
        if (load) act_duty[i] <= clamped[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_per   <= PER_RESET;
      st_mode  <= MODE_INDEP;
      act_per  <= PER_RESET;
      act_mode <= MODE_INDEP;
    end else begin
      if (wr_en && wr_sel == SEL_PERIOD) st_per  <= wr_data;
      if (wr_en && wr_sel == SEL_MODE)   st_mode <= pwm_mode_e'(wr_data[1:0]);
      if (load) begin
        act_per  <= st_per;
        act_mode <= st_mode;
      end
    end
  end

  assign act_duty_a = act_duty[0];
  assign act_duty_b = act_duty[1];
  assign nxt_mode   = st_mode;

  // R3: active settings move only on a period boundary
  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_per) && $stable(act_mode) &&
               $stable(act_duty_a) && $stable(act_duty_b)))
    else $error("active settings changed away from a boundary");
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] per,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = (cnt == per);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0))
    else $error("counter did not restart after wrap");

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (cnt == $past(cnt) + 1'b1))
    else $error("counter skipped a step");
endmodule

// File: rtl/pwm_output_route.sv
module pwm_output_route
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         wrap,
  input  logic [W-1:0] duty_a,
  input  logic [W-1:0] duty_b,
  input  pwm_mode_e    mode,
  input  pwm_mode_e    nxt_mode,
  output logic         pwm_hi,
  output logic         pwm_lo
);
  logic phase;
  logic hit_a, hit_b;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= 1'b0;
    else if (wrap)
      phase <= (mode == MODE_PUSHPULL && nxt_mode == MODE_PUSHPULL) ? ~phase : 1'b0;
  end

  assign hit_a = (cnt < duty_a);
  assign hit_b = (cnt < duty_b);

  always_comb begin
    unique case (mode)
      MODE_INDEP:    begin pwm_hi = hit_a;          pwm_lo = hit_b;         end
      MODE_COMPL:    begin pwm_hi = hit_a;          pwm_lo = ~hit_a;        end
      MODE_REDUN:    begin pwm_hi = hit_a;          pwm_lo = hit_a;         end
      MODE_PUSHPULL: begin pwm_hi = hit_a & ~phase; pwm_lo = hit_a & phase; end
      default:       begin pwm_hi = 1'b0;           pwm_lo = 1'b0;          end
    endcase
  end

  p_pp_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PUSHPULL) |-> !(pwm_hi && pwm_lo))
    else $error("push-pull drove both sides");

  p_pp_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode == MODE_PUSHPULL && nxt_mode == MODE_PUSHPULL) |=> (phase != $past(phase)))
    else $error("push-pull did not swap sides");

  p_zero_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_a == '0) |-> !pwm_hi)
    else $error("zero duty produced a high-side pulse");

  p_compl_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_COMPL) |-> (pwm_hi != pwm_lo))
    else $error("complementary pair not inverse");
endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen
  import pwm_pkg::*;
#(
  parameter int           W         = 16,
  parameter logic [W-1:0] PER_RESET = '1,
  parameter logic [W-1:0] DUTY_MIN  = 8,
  parameter logic [W-1:0] DUTY_MAX  = 16'hFFEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         pwm_hi,
  output logic         pwm_lo
);
  logic [W-1:0] cnt, act_per, act_duty_a, act_duty_b;
  logic         wrap;
  pwm_mode_e    act_mode, nxt_mode;

  pwm_period_counter #(.W(W)) u_counter (
    .clk (clk), .rst_n (rst_n), .per (act_per), .cnt (cnt), .wrap (wrap)
  );

  pwm_shadow_regs #(
    .W(W), .PER_RESET(PER_RESET), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (reg_sel_e'(wr_sel)),
    .wr_data    (wr_data),
    .load       (wrap),
    .act_duty_a (act_duty_a),
    .act_duty_b (act_duty_b),
    .act_per    (act_per),
    .act_mode   (act_mode),
    .nxt_mode   (nxt_mode)
  );

  pwm_output_route #(.W(W)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .wrap     (wrap),
    .duty_a   (act_duty_a),
    .duty_b   (act_duty_b),
    .mode     (act_mode),
    .nxt_mode (nxt_mode),
    .pwm_hi   (pwm_hi),
    .pwm_lo   (pwm_lo)
  );
endmodule

// File: tb/pwm_dual_gen_tb.sv
`timescale 1ns/1ps
module pwm_dual_gen_tb;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic pwm_hi, pwm_lo;

  int total = 0;
  int fails = 0;
  bit checking = 1'b0;
  string tag_ovr = "R1";

  always #2 clk = ~clk;

  pwm_dual_gen #(.W(W), .PER_RESET(16'd15)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  // Reference model built from the requirements
  logic [W-1:0] m_sa, m_sb, m_sp, m_aa, m_ab, m_ap, m_cnt;
  logic [1:0]   m_sm, m_am;
  logic         m_ph;

  function automatic logic [W-1:0] clampd(input logic [W-1:0] d);
    if (d == 0) return 0;
    if (d < 16'd8) return 16'd8;
    if (d > 16'hFFEF) return 16'hFFEF;
    return d;
  endfunction

  function automatic logic [1:0] expect_out(input logic [1:0] md, input logic ph,
      input logic [W-1:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    logic ha, hb;
    ha = c < a; hb = c < b;
    case (md)
      2'd0: return {ha, hb};
      2'd1: return {ha, ~ha};
      2'd2: return {ha, ha};
      default: return ph ? {1'b0, ha} : {ha, 1'b0};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sa <= 0; m_sb <= 0; m_sp <= 16'd15; m_sm <= 0;
      m_aa <= 0; m_ab <= 0; m_ap <= 16'd15; m_am <= 0;
      m_cnt <= 0; m_ph <= 0;
    end else begin
      if (wr_en) case (wr_sel)
        2'd0: m_sa <= wr_data;
        2'd1: m_sb <= wr_data;
        2'd2: m_sp <= wr_data;
        default: m_sm <= wr_data[1:0];
      endcase
      if (m_cnt == m_ap) begin
        m_cnt <= 0;
        m_aa <= clampd(m_sa); m_ab <= clampd(m_sb);
        m_ap <= m_sp; m_am <= m_sm;
        m_ph <= (m_am == 2'd3 && m_sm == 2'd3) ? ~m_ph : 1'b0;
      end else m_cnt <= m_cnt + 1'b1;
    end
  end

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Cycle-by-cycle comparison, sampled on the falling edge
  always @(negedge clk) begin
    if (checking) begin
      logic [1:0] e;
      if (!rst_n) e = 2'b00;
      else e = expect_out(m_am, m_ph, m_cnt, m_aa, m_ab);
      total++;
      if ({pwm_hi, pwm_lo} !== e) begin
        fails++;
        $display("FAIL %s: cycle cnt=%0d {hi,lo} actual=%b expected=%b",
                 (tag_ovr != "") ? tag_ovr : mode_tag(m_am), m_cnt, {pwm_hi, pwm_lo}, e);
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_wraps(input int n);
    repeat (n) begin
      do @(negedge clk); while (m_cnt != m_ap);
      @(negedge clk);
    end
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Counts high cycles over one period; call at the first cycle of a period
  task automatic measure(input string tag, input int len, input int exp_hi, input int exp_lo);
    int nh = 0, nl = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm_hi) nh++;
      if (pwm_lo) nl++;
      @(negedge clk);
    end
    check_val({tag, " high-side count"}, nh, exp_hi);
    check_val({tag, " low-side count"}, nl, exp_lo);
  endtask

  function automatic logic [W-1:0] pick_duty();
    int k = $urandom_range(0, 7);
    case (k)
      0: return 0;
      1: return W'($urandom_range(1, 7));
      2: return W'($urandom_range(16'hFFF0, 16'hFFFF));
      default: return W'($urandom_range(0, 45));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    checking = 1'b1;
    // R1: reset state
    repeat (3) @(negedge clk);
    check_val("R1 hi during reset", int'(pwm_hi), 0);
    check_val("R1 lo during reset", int'(pwm_lo), 0);
    rst_n = 1'b1;
    measure("R1", 16, 0, 0);

    // R3: staged writes invisible until the boundary
    tag_ovr = "R3";
    wr(2'd0, 16'd12); wr(2'd1, 16'd30); wr(2'd2, 16'd23); wr(2'd3, 16'd0);
    wait_wraps(1);
    tag_ovr = "R4";
    measure("R4", 24, 12, 24);
    // R2: period length between rising edges
    begin
      int n = 0;
      @(posedge pwm_hi); @(negedge clk);
      do begin n++; @(negedge clk); end while (!(pwm_hi && m_cnt == 0));
      check_val("R2 period length", n, 24);
    end

    // R9: zero duty
    tag_ovr = "R9";
    wr(2'd0, 16'd0); wr(2'd1, 16'd10);
    wait_wraps(1);
    measure("R9", 24, 0, 10);

    // R10: lower clamp
    tag_ovr = "R10";
    wr(2'd0, 16'd3); wr(2'd1, 16'd1);
    wait_wraps(1);
    measure("R10", 24, 8, 8);

    // R5 complementary, R8 duty B ignored
    tag_ovr = "R5";
    wr(2'd0, 16'd10); wr(2'd3, 16'd1);
    wait_wraps(1);
    measure("R5", 24, 10, 14);
    tag_ovr = "R8";
    wr(2'd1, 16'd3);
    wait_wraps(1);
    measure("R8 complementary", 24, 10, 14);

    // R6 redundant
    tag_ovr = "R6";
    wr(2'd0, 16'd17); wr(2'd3, 16'd2);
    wait_wraps(1);
    measure("R6", 24, 17, 17);

    // R7 push-pull alternation
    tag_ovr = "R7";
    wr(2'd0, 16'd9); wr(2'd1, 16'd20); wr(2'd3, 16'd3);
    wait_wraps(1);
    measure("R7 first period", 24, 9, 0);
    measure("R7 second period", 24, 0, 9);
    measure("R7 third period", 24, 9, 0);

    // R11: upper clamp in one long period
    tag_ovr = "R11";
    wr(2'd2, 16'hFFF0); wr(2'd0, 16'hFFFF); wr(2'd3, 16'd2);
    wait_wraps(1);
    fork
      measure("R11", 32'hFFF1, 32'hFFEF, 32'hFFEF);
      begin wr(2'd2, 16'd20); wr(2'd0, 16'd5); end
    join

    // Constrained random mix, all cycles compared with the model
    tag_ovr = "";
    for (int it = 0; it < 150; it++) begin
      int nw = $urandom_range(1, 4);
      for (int j = 0; j < nw; j++) begin
        int s = $urandom_range(0, 3);
        case (s)
          0: wr(2'd0, pick_duty());
          1: wr(2'd1, pick_duty());
          2: wr(2'd2, W'($urandom_range(8, 40)));
          default: wr(2'd3, W'($urandom_range(0, 3)));
        endcase
      end
      wait_wraps($urandom_range(1, 3));
    end

    checking = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule